// File: doc/BRIEF.md
# Partial-Store Edge Mask Generator

This block produces the lane-enable mask that a block-copy or block-fill loop needs for its first and last partial 8-byte groups. It takes a start address and an end address and returns, right-aligned and zero-extended to 64 bits, one bit for each element lane of the start address's aligned 8-byte group that lies inside the range. Elements can be bytes, halfwords or words, and the lanes can be numbered in big- or little-endian order.

Each lane is enabled when two conditions hold. The first is that the lane is at or after the start offset. The second applies only when both addresses fall in the same aligned group, and requires that the lane is at or before the end offset. The group comparison can be restricted to the low 32 address bits for 32-bit addressing. Some variants also produce integer condition codes from the subtraction start minus end, for both 64-bit and 32-bit operand views, together with a strobe that says the flags are to be written.

Operations enter through a valid/ready handshake. The result sits in a single output register until it is taken.

Top module: `edge_mask_unit`

## Requirements
- R1: `funcCode[3:2]` selects the element width: 0 for byte, 1 for halfword, 2 for word. Value 3 is illegal. An accepted illegal operation produces no `outValid`, and `illegalOp` is high for exactly the one cycle after it is accepted.
- R2: Byte width. There are 8 lanes and the offset is address bits [2:0]. Lane k is the k-th byte in address order. In big-endian mode (`funcCode[1]`=0) lane k drives mask bit 7-k. In little-endian mode (`funcCode[1]`=1) lane k drives bit k.
- R3: Halfword width. There are 4 lanes and the offset is address bits [2:1]. Big-endian mode maps lane k to bit 3-k. Little-endian mode maps lane k to bit k.
- R4: Word width. There are 2 lanes and the offset is address bit 2. Big-endian mode maps lane k to bit 1-k. Little-endian mode maps lane k to bit k.
- R5: A lane is enabled when its index is at least the start offset. If the two addresses agree in every compared bit above bit 2, the lane must also have an index no greater than the end offset.
- R6: When `addrMode32` is 1, address bits [63:32] are left out of the same-group comparison. When it is 0, all of bits [63:3] are compared.
- R7: The flags are {N,Z,V,C} of start minus end. C means a borrow, that is, start is below end unsigned. `ccFlags64` uses the full 64 bits and `ccFlags32` uses the low 32 bits.
- R8: `funcCode[0]`=0 selects a flag-setting variant. It loads the flags and raises `flagWrite` while its result is presented. `funcCode[0]`=1 leaves both flag outputs unchanged and keeps `flagWrite` low.
- R9: `maskOut` bits above the lane count are zero.
- R10: `inReady` is high when the output register is empty or is being taken. While `outValid` is high and `outReady` is low, `outValid` and `maskOut` hold steady.
- R11: Synchronous active-low reset clears `outValid`, `illegalOp`, `flagWrite` and both flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An operation is presented |
| inReady | output | 1 | The operation is accepted this cycle |
| funcCode | input | 4 | Width [3:2], little-endian [1], no-flags [0] |
| addrMode32 | input | 1 | Compare only the low 32 address bits |
| startAddr | input | 64 | Start address, indexes the leading edge |
| endAddr | input | 64 | End address, indexes the trailing edge |
| outValid | output | 1 | The result is valid |
| outReady | input | 1 | The consumer takes the result |
| maskOut | output | 64 | Zero-extended lane mask |
| flagWrite | output | 1 | The presented result carries flags |
| ccFlags64 | output | 4 | {N,Z,V,C} of the 64-bit subtraction |
| ccFlags32 | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| illegalOp | output | 1 | One-cycle pulse for width code 3 |

## Verification
The case that is hardest to reach is a pair of addresses that differ only in their upper 32 bits. Such a pair is a single group in 32-bit address mode and two separate groups in full mode, so the stimulus has to build it on purpose. The sweep therefore crosses every function code and every pair of start and end offsets with three address relations: same group, different low group bits, and different upper half only. Each of these combinations runs under both address modes. Flag retention is checked by comparing each no-flag result against the flags from the most recent flag-setting operation.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  localparam int GROUP_BYTES = 8;
  localparam int OFFS_W      = $clog2(GROUP_BYTES);
  localparam int NUM_WIDTHS  = 3;

  typedef enum logic [1:0] {
    ELEM_BYTE = 2'd0,
    ELEM_HALF = 2'd1,
    ELEM_WORD = 2'd2,
    ELEM_BAD  = 2'd3
  } elem_width_e;

  typedef struct packed {
    logic loadResult;
    logic loadFlags;
    logic setIllegal;
  } ctrl_strobe_t;
endpackage

// File: rtl/edge_mask_ctrl.sv
module edge_mask_ctrl
  import edge_mask_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [3:0]   funcCode,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output logic         illegalOp,
  output ctrl_strobe_t strobe
);
  logic accept;
  logic legalOp;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;
  assign legalOp = elem_width_e'(funcCode[3:2]) != ELEM_BAD;

  always_comb begin
    strobe.loadResult = accept && legalOp;
    strobe.loadFlags  = accept && legalOp && !funcCode[0];
    strobe.setIllegal = accept && !legalOp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      illegalOp <= strobe.setIllegal;
      if (strobe.loadResult) outValid <= 1'b1;
      else if (outReady)     outValid <= 1'b0;
    end
  end

  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  p_illegal_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> $past(inValid && inReady && funcCode[3:2] == 2'd3));

  p_illegal_noresult_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && funcCode[3:2] == 2'd3 |=> !outValid);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && funcCode[3:2] != 2'd3 |=> outValid);
endmodule

// File: rtl/edge_mask_dp.sv
module edge_mask_dp
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [3:0]        funcCode,
  input  logic              addrMode32,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] maskOut,
  output logic              flagWrite,
  output logic [3:0]        ccFlags64,
  output logic [3:0]        ccFlags32
);
  localparam int MSB = ADDR_W - 1;

  logic [GROUP_BYTES-1:0] leftSel  [NUM_WIDTHS];
  logic [GROUP_BYTES-1:0] rightSel [NUM_WIDTHS];
  logic                   littleEnd;
  logic [ADDR_W-1:0]      cmpMask;
  logic                   sameGroup;
  logic [GROUP_BYTES-1:0] leftMask, rightMask, laneMask;
  logic [ADDR_W:0]        diffWide;
  logic [32:0]            diffNarrow;
  logic [3:0]             flagsWide, flagsNarrow;
  logic                   ccQ;

  assign littleEnd = funcCode[1];

  // One edge lookup per element width: lanes shrink as elements grow.
  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int LANES = GROUP_BYTES >> g;
    localparam int IDX_W = OFFS_W - g;
    logic [LANES-1:0] fullLanes;
    logic [IDX_W-1:0] idxStart, idxEnd;
    logic [LANES-1:0] leftBe, leftLe, rightBe, rightLe;

    assign fullLanes = '1;
    assign idxStart  = startAddr[OFFS_W-1:g];
    assign idxEnd    = endAddr[OFFS_W-1:g];
    assign leftBe    = fullLanes >> idxStart;
    assign leftLe    = fullLanes << idxStart;
    assign rightBe   = ~(fullLanes >> (32'(idxEnd) + 32'd1));
    assign rightLe   = fullLanes >> (32'(LANES - 1) - 32'(idxEnd));
    assign leftSel[g]  = GROUP_BYTES'(littleEnd ? leftLe  : leftBe);
    assign rightSel[g] = GROUP_BYTES'(littleEnd ? rightLe : rightBe);
  end

  always_comb begin
    case (elem_width_e'(funcCode[3:2]))
      ELEM_HALF: begin leftMask = leftSel[1]; rightMask = rightSel[1]; end
      ELEM_WORD: begin leftMask = leftSel[2]; rightMask = rightSel[2]; end
      default:   begin leftMask = leftSel[0]; rightMask = rightSel[0]; end
    endcase
  end

  always_comb begin
    cmpMask = {ADDR_W{1'b1}} << OFFS_W;
    if (addrMode32) cmpMask[MSB:32] = '0;
  end

  assign sameGroup = ((startAddr ^ endAddr) & cmpMask) == '0;
  assign laneMask  = sameGroup ? (leftMask & rightMask) : leftMask;

  // Flags of start - end, both operand views.
  assign diffWide   = {1'b0, startAddr} - {1'b0, endAddr};
  assign diffNarrow = {1'b0, startAddr[31:0]} - {1'b0, endAddr[31:0]};
  assign flagsWide  = {diffWide[MSB], diffWide[MSB:0] == '0,
                       (startAddr[MSB] ^ endAddr[MSB]) & (diffWide[MSB] ^ startAddr[MSB]),
                       diffWide[ADDR_W]};
  assign flagsNarrow = {diffNarrow[31], diffNarrow[31:0] == 32'd0,
                        (startAddr[31] ^ endAddr[31]) & (diffNarrow[31] ^ startAddr[31]),
                        diffNarrow[32]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskOut   <= '0;
      ccQ       <= 1'b0;
      ccFlags64 <= '0;
      ccFlags32 <= '0;
    end else begin
      if (strobe.loadResult) begin
        maskOut <= ADDR_W'(laneMask);
        ccQ     <= strobe.loadFlags;
      end
      if (strobe.loadFlags) begin
        ccFlags64 <= flagsWide;
        ccFlags32 <= flagsNarrow;
      end
    end
  end

  assign flagWrite = outValid && ccQ;

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(maskOut));

  p_nocc_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult && !strobe.loadFlags |=> $stable(ccFlags64) && $stable(ccFlags32));

  p_zext_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> maskOut[MSB:GROUP_BYTES] == '0);
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [3:0]        funcCode,
  input  logic              addrMode32,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] maskOut,
  output logic              flagWrite,
  output logic [3:0]        ccFlags64,
  output logic [3:0]        ccFlags32,
  output logic              illegalOp
);
  ctrl_strobe_t strobe;

  edge_mask_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcCode(funcCode),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .illegalOp(illegalOp), .strobe(strobe)
  );

  edge_mask_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .funcCode(funcCode),
    .addrMode32(addrMode32), .startAddr(startAddr), .endAddr(endAddr),
    .outValid(outValid), .outReady(outReady), .maskOut(maskOut),
    .flagWrite(flagWrite), .ccFlags64(ccFlags64), .ccFlags32(ccFlags32)
  );
endmodule

// File: tb/edge_mask_unit_tb_top.sv
module edge_mask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  funcCode = '0;
  logic        addrMode32 = 1'b0;
  logic [63:0] startAddr = '0;
  logic [63:0] endAddr = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] maskOut;
  logic        flagWrite;
  logic [3:0]  ccFlags64, ccFlags32;
  logic        illegalOp;

  int checks = 0;
  int fails = 0;
  logic [3:0] lastF64 = '0;
  logic [3:0] lastF32 = '0;

  always #5 clk = ~clk;

  edge_mask_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .funcCode(funcCode), .addrMode32(addrMode32), .startAddr(startAddr),
    .endAddr(endAddr), .outValid(outValid), .outReady(outReady),
    .maskOut(maskOut), .flagWrite(flagWrite), .ccFlags64(ccFlags64),
    .ccFlags32(ccFlags32), .illegalOp(illegalOp)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Lane-by-lane model: lane k is the k-th element in address order.
  function automatic logic [63:0] expMask(int wsel, bit le, logic [63:0] s,
                                          logic [63:0] e, bit am);
    int lanes = 8 >> wsel;
    int iS = int'(s[2:0]) >> wsel;
    int iE = int'(e[2:0]) >> wsel;
    logic [63:0] cmp = am ? 64'h0000_0000_FFFF_FFF8 : 64'hFFFF_FFFF_FFFF_FFF8;
    bit same = ((s ^ e) & cmp) == 64'd0;
    logic [63:0] r = '0;
    for (int k = 0; k < lanes; k++) begin
      bit on = (k >= iS) && (!same || k <= iE);
      if (on) r[le ? k : lanes - 1 - k] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [3:0] expFlags64(logic [63:0] s, logic [63:0] e);
    logic [63:0] d = s - e;
    bit n = d[63];
    bit v = ($signed(s) < $signed(e)) != n;
    return {n, d == 64'd0, v, s < e};
  endfunction

  function automatic logic [3:0] expFlags32(logic [31:0] s, logic [31:0] e);
    logic [31:0] d = s - e;
    bit n = d[31];
    bit v = ($signed(s) < $signed(e)) != n;
    return {n, d == 32'd0, v, s < e};
  endfunction

  task automatic applyOp(logic [3:0] fc, bit am, logic [63:0] s, logic [63:0] e);
    string wtag;
    funcCode = fc; addrMode32 = am; startAddr = s; endAddr = e;
    inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    if (fc[3:2] == 2'd3) begin
      check("R1 illegal pulse", 64'(illegalOp), 64'd1);
      check("R1 no result", 64'(outValid), 64'd0);
      check("R8 flags kept on illegal", {ccFlags64, ccFlags32}, {lastF64, lastF32});
      return;
    end
    wtag = (fc[3:2] == 2'd0) ? "R2/R5/R6/R9 byte mask" :
           (fc[3:2] == 2'd1) ? "R3/R5/R6/R9 half mask" : "R4/R5/R6/R9 word mask";
    check("R10 result valid", 64'(outValid), 64'd1);
    check(wtag, maskOut, expMask(int'(fc[3:2]), fc[1], s, e, am));
    if (!fc[0]) begin
      lastF64 = expFlags64(s, e);
      lastF32 = expFlags32(s[31:0], e[31:0]);
      check("R8 flagWrite set", 64'(flagWrite), 64'd1);
    end else begin
      check("R8 flagWrite clear", 64'(flagWrite), 64'd0);
    end
    check("R7 flags64", 64'(ccFlags64), 64'(lastF64));
    check("R7 flags32", 64'(ccFlags32), 64'(lastF32));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [63:0] base, s, e, expA;
    repeat (4) @(negedge clk);
    check("R11 outValid after reset", 64'(outValid), 64'd0);
    check("R11 illegalOp after reset", 64'(illegalOp), 64'd0);
    check("R11 flags after reset", {ccFlags64, ccFlags32}, 64'd0);
    check("R11 flagWrite after reset", 64'(flagWrite), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 ready when empty", 64'(inReady), 64'd1);

    base = 64'h8765_4321_0FED_CB90;
    for (int rel = 0; rel < 3; rel++)
      for (int am = 0; am < 2; am++)
        for (int fc = 0; fc < 16; fc++)
          for (int so = 0; so < 8; so++)
            for (int eo = 0; eo < 8; eo++) begin
              s = base + 64'(so) + 64'(rel * 24 + fc);
              s[2:0] = 3'(so);
              e = s;
              e[2:0] = 3'(eo);
              if (rel == 1) e = e + 64'h40;
              if (rel == 2) e[63:32] = ~s[63:32];
              applyOp(4'(fc), am[0], s, e);
            end

    // Illegal pulse lasts one cycle (R1).
    applyOp(4'hC, 1'b0, 64'h10, 64'h20);
    @(negedge clk);
    check("R1 illegal pulse ends", 64'(illegalOp), 64'd0);

    // Output holds while consumer stalls (R10).
    funcCode = 4'h0; addrMode32 = 1'b0; startAddr = 64'h101; endAddr = 64'h106;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    expA = 64'h7E;
    startAddr = 64'h200; endAddr = 64'h203; funcCode = 4'h2;
    for (int i = 0; i < 3; i++) begin
      check("R10 stalled valid", 64'(outValid), 64'd1);
      check("R10 stalled ready low", 64'(inReady), 64'd0);
      check("R10 stalled mask", maskOut, expA);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R10 next result after release", maskOut, 64'h0F);
    check("R10 valid after release", 64'(outValid), 64'd1);
    @(negedge clk);
    check("R10 drained", 64'(outValid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule